// File: doc/BRIEF.md
# Two-Level Address Translation Cache

This block holds recently used virtual-to-physical page translations so a requester can turn a 48-bit virtual address into a 40-bit physical address without walking page tables. It has two levels. The first level is a fully associative pair of arrays: one for 4 KB mappings and one for large mappings (2 MB or 4 MB). The second level is a bigger set-associative array that keeps 4 KB mappings only.

A lookup presents a virtual address for one cycle. A first-level hit answers on the next clock. A first-level miss reads the second level, which answers one cycle later. When the second level hits, it also copies the translation into the first-level small-page array. A miss in both levels is returned as a miss so that an external walker can supply the translation through the fill port. 4 KB fills go into the second level. Large fills go into the first-level large array. Each array, and each second-level set, replaces its entries in round-robin order. A flush input empties both levels in one cycle.

Top module: `tlb2l`

## Requirements
- R1: After reset, `rsp_valid` is low, and every lookup misses: `rsp_hit`=0 and `rsp_level`=1, with the response two clocks after the request.
- R2: A fill with `fill_size`=00 (4 KB) writes only the second level. The first lookup of that page answers two clocks after the request with `rsp_hit`=1, `rsp_level`=1 and `rsp_paddr`={`fill_paddr`[39:12], `lk_vaddr`[11:0]}.
- R3: A second-level hit writes the translation into the first-level small array. The next lookup of that page answers one clock after the request with `rsp_level`=0 and the same physical address.
- R4: A fill with `fill_size`=01 (2 MB) writes the first-level large array. Any address in that 2 MB region answers in one clock with `rsp_level`=0 and `rsp_paddr`={`fill_paddr`[39:21], `lk_vaddr`[20:0]}. An address in the neighbouring 2 MB region misses.
- R5: A fill with `fill_size`=1x (4 MB) ignores virtual bit 21 when matching. The physical address is {`fill_paddr`[39:22], `lk_vaddr`[21:0]}, so `fill_paddr` bit 21 has no effect.
- R6: A miss in both levels answers two clocks after the request with `rsp_hit`=0, `rsp_level`=1 and `rsp_paddr`=0.
- R7: The 8-entry large array replaces in round-robin order. The ninth large fill evicts the first one, and the others stay.
- R8: The 32-entry small array replaces in round-robin order. The 33rd refill evicts the oldest refilled page, and that page is then served again from the second level (`rsp_level`=1).
- R9: Each 4-way second-level set (index = virtual bits [18:12]) replaces in round-robin order. The fifth fill into a set evicts the first one filled there, and other sets keep their contents.
- R10: One cycle of `flush` invalidates every entry in both levels. Lookups that follow miss, including pages that were held in either first-level array.
- R11: Every response holds `rsp_valid` high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries in both levels |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | VA_W | Virtual address to translate |
| fill_valid | input | 1 | Fill request strobe |
| fill_vaddr | input | VA_W | Virtual page of the new translation |
| fill_paddr | input | PA_W | Physical frame of the new translation |
| fill_size | input | 2 | Page size: 00 = 4 KB, 01 = 2 MB, 1x = 4 MB |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_level | output | 1 | 0 = answered by first level, 1 = by second level |
| rsp_paddr | output | PA_W | Translated physical address, zero on a miss |

## Verification
The assertions assume a well-behaved requester. It keeps at most one lookup in flight, so it issues no lookup or fill while a second-level read is pending. It never fills in the same cycle as a lookup. It never installs two translations that cover the same virtual page. The bench drives requests one at a time through tasks that wait for each response, and it leaves an idle cycle after every fill. It gives every installed page its own virtual page, and it places small and large pages in separate address regions, so no two entries can match one lookup. Because of these assumptions, a match in two ways or entries at once is treated as a broken invariant and not as a legal input.

// File: rtl/tlb2l_pkg.sv
package tlb2l_pkg;
  // page-size encodings on the fill port
  localparam logic [1:0] SZ_4K = 2'b00;
  localparam logic [1:0] SZ_2M = 2'b01;
  // offset widths of the supported page sizes
  localparam int OFS_SMALL = 12;
  localparam int OFS_LARGE = 21;
  // which level produced a response
  localparam logic LVL_FIRST  = 1'b0;
  localparam logic LVL_SECOND = 1'b1;
endpackage

// File: rtl/tlb2l_l1small.sv
module tlb2l_l1small #(
  parameter int N     = 32,
  parameter int VPN_W = 36,
  parameter int PPN_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn
);
  localparam int PTR_W = $clog2(N);

  logic [N-1:0]     vld;
  logic [VPN_W-1:0] tag [N];
  logic [PPN_W-1:0] ppn [N];
  logic [PTR_W-1:0] rr;
  logic [N-1:0]     match;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
      rr  <= '0;
    end else if (wr_en) begin
      vld[rr] <= 1'b1;
      rr      <= (rr == PTR_W'(N-1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag[rr] <= wr_vpn;
      ppn[rr] <= wr_ppn;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = vld[i] && (tag[i] == lk_vpn);
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) hit_ppn = hit_ppn | ppn[i];
  end
  assign hit = |match;

  // R3: refills only happen on a miss, so one page never sits in two entries
  assert_unique_small_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/tlb2l_l1large.sv
module tlb2l_l1large #(
  parameter int N     = 8,
  parameter int VPN_W = 27,
  parameter int FR_W  = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic             hit_big,
  output logic [FR_W-1:0]  hit_fr,
  input  logic             wr_en,
  input  logic             wr_big,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [FR_W-1:0]  wr_fr
);
  localparam int PTR_W = $clog2(N);

  logic [N-1:0]     vld;
  logic [N-1:0]     big;
  logic [VPN_W-1:0] tag [N];
  logic [FR_W-1:0]  fr  [N];
  logic [PTR_W-1:0] rr;
  logic [N-1:0]     match;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
      rr  <= '0;
    end else if (wr_en) begin
      vld[rr] <= 1'b1;
      rr      <= (rr == PTR_W'(N-1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag[rr] <= wr_vpn;
      fr[rr]  <= wr_fr;
      big[rr] <= wr_big;
    end
  end

  // lowest tag bit is virtual bit 21, a don't-care for 4 MB entries
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = vld[i] && (tag[i][VPN_W-1:1] == lk_vpn[VPN_W-1:1])
                      && (big[i] || (tag[i][0] == lk_vpn[0]));
  end

  always_comb begin
    hit_fr  = '0;
    hit_big = 1'b0;
    for (int i = 0; i < N; i++)
      if (match[i]) begin
        hit_fr  = hit_fr | fr[i];
        hit_big = hit_big | big[i];
      end
  end
  assign hit = |match;

  // R4/R5: large regions handed in by the walker never overlap
  assert_unique_large_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/tlb2l_l2.sv
module tlb2l_l2 #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int VPN_W = 36,
  parameter int PPN_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             rd_en,
  input  logic [VPN_W-1:0] rd_vpn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = VPN_W - IDX_W;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] wr_tag, req_tag_q;
  logic [WAYS-1:0]  vld [SETS];
  logic [WAY_W-1:0] rr  [SETS];
  logic [WAYS-1:0]  vld_q;
  logic [WAY_W-1:0] victim;
  logic [WAYS-1:0]  hit_w;
  logic [WAYS-1:0][PPN_W-1:0] ppn_m;

  assign rd_idx = rd_vpn[IDX_W-1:0];
  assign wr_idx = wr_vpn[IDX_W-1:0];
  assign wr_tag = wr_vpn[VPN_W-1:IDX_W];
  assign victim = rr[wr_idx];

  // valid bits and pointers in flops so a flush clears them in one cycle
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        rr[s]  <= '0;
      end
      vld_q <= '0;
    end else begin
      if (wr_en) begin
        vld[wr_idx][victim] <= 1'b1;
        rr[wr_idx] <= (victim == WAY_W'(WAYS-1)) ? '0 : victim + 1'b1;
      end
      if (rd_en) vld_q <= vld[rd_idx];
    end
  end

  always_ff @(posedge clk)
    if (rd_en) req_tag_q <= rd_vpn[VPN_W-1:IDX_W];

  // one RAM per way with a registered read port
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [PPN_W-1:0] ppn_mem [SETS];
    logic [TAG_W-1:0] tag_q;
    logic [PPN_W-1:0] ppn_q;

    always_ff @(posedge clk) begin
      if (wr_en && (victim == WAY_W'(w))) begin
        tag_mem[wr_idx] <= wr_tag;
        ppn_mem[wr_idx] <= wr_ppn;
      end
      if (rd_en) begin
        tag_q <= tag_mem[rd_idx];
        ppn_q <= ppn_mem[rd_idx];
      end
    end

    assign hit_w[w] = vld_q[w] && (tag_q == req_tag_q);
    assign ppn_m[w] = ppn_q & {PPN_W{hit_w[w]}};
  end

  always_comb begin
    hit_ppn = '0;
    for (int w = 0; w < WAYS; w++) hit_ppn = hit_ppn | ppn_m[w];
  end
  assign hit = |hit_w;

  // R9: a page is filled once, so at most one way matches
  assert_unique_way_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_w));
  // R2: fills and lookups never share a cycle
  assert_no_rw_clash_R2: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));
endmodule

// File: rtl/tlb2l.sv
module tlb2l
  import tlb2l_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int L1S_N   = 32,
  parameter int L1L_N   = 8,
  parameter int L2_SETS = 128,
  parameter int L2_WAYS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_vaddr,
  input  logic            fill_valid,
  input  logic [VA_W-1:0] fill_vaddr,
  input  logic [PA_W-1:0] fill_paddr,
  input  logic [1:0]      fill_size,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_level,
  output logic [PA_W-1:0] rsp_paddr
);
  localparam int SVPN_W = VA_W - OFS_SMALL;
  localparam int PPN_W  = PA_W - OFS_SMALL;
  localparam int LVPN_W = VA_W - OFS_LARGE;
  localparam int FR_W   = PA_W - OFS_LARGE;

  logic             s_hit, l_hit, l_big, l2_hit, l1_hit;
  logic [PPN_W-1:0] s_ppn, l2_ppn;
  logic [FR_W-1:0]  l_fr;
  logic [PA_W-1:0]  l1_pa;
  logic             pend;
  logic [VA_W-1:0]  pend_va;
  logic             fill_small, fill_large, refill;
  logic             unused_low;

  assign unused_low = ^{fill_vaddr[OFS_SMALL-1:0], fill_paddr[OFS_SMALL-1:0]};
  assign fill_small = fill_valid && (fill_size == SZ_4K);
  assign fill_large = fill_valid && (fill_size != SZ_4K);
  assign refill     = pend && l2_hit;

  tlb2l_l1small #(.N(L1S_N), .VPN_W(SVPN_W), .PPN_W(PPN_W)) u_small (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_vpn(lk_vaddr[VA_W-1:OFS_SMALL]), .hit(s_hit), .hit_ppn(s_ppn),
    .wr_en(refill), .wr_vpn(pend_va[VA_W-1:OFS_SMALL]), .wr_ppn(l2_ppn));

  tlb2l_l1large #(.N(L1L_N), .VPN_W(LVPN_W), .FR_W(FR_W)) u_large (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_vpn(lk_vaddr[VA_W-1:OFS_LARGE]), .hit(l_hit), .hit_big(l_big),
    .hit_fr(l_fr), .wr_en(fill_large), .wr_big(fill_size[1]),
    .wr_vpn(fill_vaddr[VA_W-1:OFS_LARGE]), .wr_fr(fill_paddr[PA_W-1:OFS_LARGE]));

  tlb2l_l2 #(.SETS(L2_SETS), .WAYS(L2_WAYS), .VPN_W(SVPN_W), .PPN_W(PPN_W)) u_l2 (
    .clk(clk), .rst(rst), .flush(flush),
    .rd_en(lk_valid), .rd_vpn(lk_vaddr[VA_W-1:OFS_SMALL]),
    .wr_en(fill_small), .wr_vpn(fill_vaddr[VA_W-1:OFS_SMALL]),
    .wr_ppn(fill_paddr[PA_W-1:OFS_SMALL]),
    .hit(l2_hit), .hit_ppn(l2_ppn));

  assign l1_hit = s_hit || l_hit;

  always_comb begin
    if (s_hit)
      l1_pa = {s_ppn, lk_vaddr[OFS_SMALL-1:0]};
    else if (l_big)
      l1_pa = {l_fr[FR_W-1:1], lk_vaddr[OFS_LARGE:0]};
    else
      l1_pa = {l_fr, lk_vaddr[OFS_LARGE-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_level <= LVL_FIRST;
      rsp_paddr <= '0;
      pend      <= 1'b0;
      pend_va   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (lk_valid) begin
        if (l1_hit) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_level <= LVL_FIRST;
          rsp_paddr <= l1_pa;
        end else begin
          pend    <= 1'b1;
          pend_va <= lk_vaddr;
        end
      end
      if (pend) begin
        pend      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_hit   <= l2_hit;
        rsp_level <= LVL_SECOND;
        rsp_paddr <= l2_hit ? {l2_ppn, pend_va[OFS_SMALL-1:0]} : '0;
      end
    end
  end

  // R11: one request in flight; nothing new while the second level answers
  assert_one_in_flight_R11: assert property (@(posedge clk) disable iff (rst)
    pend |-> (!lk_valid && !fill_valid));
  // R3: first-level hits answer next clock with the page offset carried through
  assert_l1_answer_R3: assert property (@(posedge clk) disable iff (rst || flush)
    (lk_valid && l1_hit) |=> (rsp_valid && rsp_hit && (rsp_level == LVL_FIRST)
      && (rsp_paddr[OFS_SMALL-1:0] == $past(lk_vaddr[OFS_SMALL-1:0]))));
  // R2: a first-level miss is silent for one clock
  assert_l1_miss_gap_R2: assert property (@(posedge clk) disable iff (rst || flush)
    (lk_valid && !l1_hit) |=> !rsp_valid);
  // R6: then the second level answers
  assert_l2_answer_R6: assert property (@(posedge clk) disable iff (rst || flush)
    (lk_valid && !l1_hit) |=> ##1 (rsp_valid && (rsp_level == LVL_SECOND)));
  // R6: misses carry a zero address
  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));
endmodule

// File: tb/tlb2l_bench.sv
module tlb2l_bench;
  localparam int VA_W = 48;
  localparam int PA_W = 40;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            flush = 1'b0;
  logic            lk_valid = 1'b0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic            fill_valid = 1'b0;
  logic [VA_W-1:0] fill_vaddr = '0;
  logic [PA_W-1:0] fill_paddr = '0;
  logic [1:0]      fill_size = 2'b00;
  logic            rsp_valid, rsp_hit, rsp_level;
  logic [PA_W-1:0] rsp_paddr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tlb2l u_tlb2l (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr),
    .fill_size(fill_size), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_level(rsp_level), .rsp_paddr(rsp_paddr));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // small pages: set index = i, frame arithmetic from i
  function automatic logic [VA_W-1:0] sva(input int i);
    return 48'h7000_0000_0000 | (48'(i) << 12) | 48'((i * 37) & 12'hfff);
  endfunction
  function automatic logic [27:0] sfr(input int i);
    return 28'h0A0_0000 + 28'(i * 3);
  endfunction
  // same-set pages for the second-level replacement sweep
  function automatic logic [VA_W-1:0] cva(input int k);
    return 48'h7000_0000_0000 | (48'd100 << 12) | (48'(k + 1) << 19) | 48'h05A;
  endfunction
  function automatic logic [27:0] cfr(input int k);
    return 28'h0B0_0000 + 28'(k);
  endfunction
  // large pages: even = 2 MB, odd = 4 MB, one 8 MB region each
  function automatic logic [VA_W-1:0] lva(input int j);
    return 48'h1000_0000_0000 + (48'(j) << 23);
  endfunction
  function automatic logic [PA_W-1:0] lfr(input int j);
    return 40'h40_0000_0000 | (40'(j) << 24) | ((j % 2 == 1) ? 40'h20_0000 : 40'h0);
  endfunction
  function automatic logic [PA_W-1:0] lexp(input int j, input logic [VA_W-1:0] va);
    logic [PA_W-1:0] m;
    m = (j % 2 == 1) ? 40'h3F_FFFF : 40'h1F_FFFF;
    return (lfr(j) & ~m) | (va[PA_W-1:0] & m);
  endfunction

  task automatic fill(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                      input logic [1:0] sz);
    @(negedge clk);
    fill_valid = 1'b1; fill_vaddr = va; fill_paddr = pa; fill_size = sz;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // issue one lookup, measure latency in clocks, check the pulse width
  task automatic look(input logic [VA_W-1:0] va, input bit e_hit, input bit e_lvl,
                      input logic [PA_W-1:0] e_pa, input int e_cyc, input string req);
    int cyc = 0;
    logic [63:0] act, exp;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0;
    if (rsp_valid) cyc = 1;
    else begin
      @(negedge clk);
      if (rsp_valid) cyc = 2;
    end
    act = {20'h0, rsp_hit, rsp_level, 2'(cyc), rsp_paddr};
    exp = {20'h0, e_hit, e_lvl, 2'(e_cyc), e_pa};
    chk(cyc != 0 && act == exp, req, "lookup {hit,lvl,cyc,pa}", act, exp);
    @(negedge clk);
    chk(!rsp_valid, "R11", "rsp_valid single pulse", 64'(rsp_valid), 64'h0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1'b1;
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rsp_valid, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rsp_valid, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
    look(sva(3), 1'b0, 1'b1, '0, 2, "R1");
    look(lva(0), 1'b0, 1'b1, '0, 2, "R1");

    // R2: 4 KB fills land in the second level only
    for (int i = 0; i < 40; i++) fill(sva(i), {sfr(i), 12'h0}, 2'b00);
    for (int i = 0; i < 40; i++)
      look(sva(i), 1'b1, 1'b1, {sfr(i), sva(i)[11:0]}, 2, "R2");
    // R3: pages 8..39 now sit in the first level
    for (int i = 8; i < 40; i++)
      look(sva(i) ^ 48'h0FF, 1'b1, 1'b0, {sfr(i), sva(i)[11:0] ^ 12'h0FF}, 1, "R3");
    // R8: pages 0..7 were evicted by refills 33..40; page 0 refill evicts page 8
    look(sva(0), 1'b1, 1'b1, {sfr(0), sva(0)[11:0]}, 2, "R8");
    look(sva(8), 1'b1, 1'b1, {sfr(8), sva(8)[11:0]}, 2, "R8");
    look(sva(0), 1'b1, 1'b0, {sfr(0), sva(0)[11:0]}, 1, "R8");

    // R9: five fills into set 100 push out the first one
    for (int k = 0; k < 5; k++) fill(cva(k), {cfr(k), 12'h0}, 2'b00);
    look(cva(0), 1'b0, 1'b1, '0, 2, "R9");
    for (int k = 1; k < 5; k++)
      look(cva(k), 1'b1, 1'b1, {cfr(k), cva(k)[11:0]}, 2, "R9");
    look(sva(5), 1'b1, 1'b1, {sfr(5), sva(5)[11:0]}, 2, "R9");
    // R6: unmapped page misses everywhere
    look(48'h2222_3333_4000, 1'b0, 1'b1, '0, 2, "R6");

    // R4 / R5: eight large fills, three offsets each
    for (int j = 0; j < 8; j++)
      fill(lva(j), lfr(j), (j % 2 == 1) ? 2'b10 : 2'b01);
    for (int j = 0; j < 8; j++) begin
      logic [VA_W-1:0] offs [3];
      if (j % 2 == 1) begin
        offs[0] = 48'h0; offs[1] = 48'h2A_BCDE; offs[2] = 48'h3F_FFFF;
      end else begin
        offs[0] = 48'h0; offs[1] = 48'h01_2345; offs[2] = 48'h1F_FFFF;
      end
      for (int o = 0; o < 3; o++)
        look(lva(j) + offs[o], 1'b1, 1'b0, lexp(j, lva(j) + offs[o]), 1,
             (j % 2 == 1) ? "R5" : "R4");
    end
    look(lva(2) + 48'h20_0000, 1'b0, 1'b1, '0, 2, "R4");
    look(lva(2) + 48'h40_0000, 1'b0, 1'b1, '0, 2, "R4");

    // R7: ninth large fill overwrites the first
    fill(lva(8), lfr(8), 2'b01);
    look(lva(0), 1'b0, 1'b1, '0, 2, "R7");
    look(lva(8) + 48'h77, 1'b1, 1'b0, lexp(8, lva(8) + 48'h77), 1, "R7");
    look(lva(1) + 48'h30_0000, 1'b1, 1'b0, lexp(1, lva(1) + 48'h30_0000), 1, "R7");

    // R10: one flush cycle empties both levels
    do_flush();
    look(sva(20), 1'b0, 1'b1, '0, 2, "R10");
    look(sva(5), 1'b0, 1'b1, '0, 2, "R10");
    look(lva(3), 1'b0, 1'b1, '0, 2, "R10");
    look(cva(2), 1'b0, 1'b1, '0, 2, "R10");
    // refill works again after a flush
    fill(sva(20), {sfr(20), 12'h0}, 2'b00);
    look(sva(20), 1'b1, 1'b1, {sfr(20), sva(20)[11:0]}, 2, "R10");
    look(sva(20), 1'b1, 1'b0, {sfr(20), sva(20)[11:0]}, 1, "R10");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule